// File: doc/BRIEF.md
# Charge-Path Protection Controller

This block decides whether the charge switch of a two-cell lithium-ion protector may conduct. Its inputs are comparator results that are already synchronous and digital: an overcharge flag and a release flag for each cell, a flag that says the charger pulls the negative terminal too far down, the present level of the discharge-side enable, a zero-volt-charge permit and a test input. A timebase tick, nominally every 0.5 ms, paces every delay.

Two qualifiers drive the fault state. One handles overcharge and the other handles the excessive charger. Each counts ticks while its condition holds without a break, and each has separate detect and release limits. The charge enable goes low while either fault is held. The zero-volt permit forces it high. Every change of the enable comes with a one-cycle event pulse and a code that names its cause. The overcharge state is also brought out so that the discharge-side logic can use it.

Top module: `charge_guard`

## Requirements
- R1: After reset `chg_en` is 1, `ovc_flag` is 0 and `evt_valid` is 0, and all delay counts start from zero.
- R2: If at least one bit of `cell_ovc` stays high for OVC_DET_TICKS consecutive ticks, `ovc_flag` goes to 1 on the clock edge that samples the last tick. `chg_en` falls one clock later.
- R3: A cycle in which no bit of `cell_ovc` is high, before the detect limit is reached, restarts the overcharge count from zero.
- R4: Overcharge is released only after both bits of `cell_rel` have stayed high for OVC_REL_TICKS consecutive ticks. While only one cell reports release, the fault holds.
- R5: If `chg_low` stays high for XC_TICKS ticks while `dsg_en` is 1, the excessive-charger fault sets and `chg_en` falls. Once set, the fault clears after `chg_low` has stayed low for XC_TICKS ticks.
- R6: If `chg_low` drops before its detect limit is reached, the pending detection is abandoned, and a later assertion counts again from zero.
- R7: While `dsg_en` is 0, the excessive-charger detect count does not advance. Counting starts once `dsg_en` is back at 1 with `chg_low` still high.
- R8: While `zero_ok` is 1, `chg_en` is 1 one clock later, whatever the fault state.
- R9: While `test_fast` is 1, every detect and release limit becomes a single tick.
- R10: Whenever `chg_en` changes, `evt_valid` is 1 for that same cycle. `evt_cause` then holds 0 for overcharge, 1 for excessive charger or 2 for the zero-volt permit. When more than one source changed, the permit takes priority over overcharge, and overcharge takes priority over the excessive charger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse |
| cell_ovc | input | 2 | Per-cell overcharge detect flags |
| cell_rel | input | 2 | Per-cell at-or-below-release flags |
| chg_low | input | 1 | Charger voltage below the excessive-charger limit |
| dsg_en | input | 1 | Present level of the discharge enable |
| zero_ok | input | 1 | Zero-volt charging permitted |
| test_fast | input | 1 | Shorten all delays to one tick |
| chg_en | output | 1 | Charge enable, high lets charging proceed |
| ovc_flag | output | 1 | Overcharge state for the discharge side |
| evt_valid | output | 1 | One-cycle pulse on each change of `chg_en` |
| evt_cause | output | 2 | Cause code carried with `evt_valid` |

## Verification
The bench stops the overcharge and excessive-charger conditions one tick short of their limits and then breaks them. A counter that was not cleared on the break would trip early, and the bench would see `chg_en` fall too soon. It releases only one cell to catch a release that uses OR in place of AND. It holds `chg_low` while the discharge side is off, to catch a qualifier that counts while it should be suppressed. Each event is checked against a queue of expected causes and levels, so a missing, extra or misattributed pulse is reported.

// File: rtl/charge_guard_pkg.sv
package charge_guard_pkg;
   typedef enum logic [1:0] {
      CAUSE_OVC  = 2'd0,
      CAUSE_XC   = 2'd1,
      CAUSE_ZERO = 2'd2
   } cause_e;
endpackage

// File: rtl/cg_delay_qual.sv
module cg_delay_qual #(
   parameter int SET_TICKS = 2000,
   parameter int CLR_TICKS = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic fast,
   input  logic set_cond,
   input  logic clr_cond,
   output logic state
);
   localparam int MAXT  = (SET_TICKS > CLR_TICKS) ? SET_TICKS : CLR_TICKS;
   localparam int CNT_W = $clog2(MAXT + 1);
   localparam logic [CNT_W-1:0] SET_M1 = CNT_W'(SET_TICKS - 1);
   localparam logic [CNT_W-1:0] CLR_M1 = CNT_W'(CLR_TICKS - 1);
   localparam logic [CNT_W-1:0] MAX_M1 = CNT_W'(MAXT - 1);

   generate
      if (SET_TICKS < 1 || CLR_TICKS < 1) begin : g_bad_limit
         $error("cg_delay_qual: tick limits must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim_m1;
   logic             go;

   always_comb begin
      go     = state ? clr_cond : set_cond;
      lim_m1 = fast ? '0 : (state ? CLR_M1 : SET_M1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         state <= 1'b0;
      end else if (!go) begin
         cnt <= '0;
      end else if (tick) begin
         if (cnt >= lim_m1) begin
            cnt   <= '0;
            state <= ~state;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= MAX_M1);  // R3
   AST_FLIP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (state != $past(state)) |-> ($past(tick) && $past(go)));  // R9
endmodule

// File: rtl/cg_event_out.sv
module cg_event_out
   import charge_guard_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ovc_st,
   input  logic       xc_st,
   input  logic       zero_ok,
   output logic       chg_en,
   output logic       evt_valid,
   output logic [1:0] evt_cause
);
   logic nxt_en;
   logic ovc_p, xc_p, zero_p;

   always_comb nxt_en = zero_ok | ~(ovc_st | xc_st);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chg_en    <= 1'b1;
         evt_valid <= 1'b0;
         evt_cause <= CAUSE_OVC;
         ovc_p     <= 1'b0;
         xc_p      <= 1'b0;
         zero_p    <= 1'b0;
      end else begin
         chg_en    <= nxt_en;
         evt_valid <= nxt_en != chg_en;
         ovc_p     <= ovc_st;
         xc_p      <= xc_st;
         zero_p    <= zero_ok;
         if (zero_ok != zero_p)     evt_cause <= CAUSE_ZERO;
         else if (ovc_st != ovc_p)  evt_cause <= CAUSE_OVC;
         else                       evt_cause <= CAUSE_XC;
      end
   end

   AST_ZERO_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(zero_ok) |-> chg_en);  // R8
   AST_EVT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(chg_en) || $fell(chg_en)) |-> evt_valid);  // R10
endmodule

// File: rtl/charge_guard.sv
module charge_guard #(
   parameter int OVC_DET_TICKS = 2000,
   parameter int OVC_REL_TICKS = 80,
   parameter int XC_TICKS      = 3,
   parameter int CELLS         = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [1:0] cell_ovc,
   input  logic [1:0] cell_rel,
   input  logic       chg_low,
   input  logic       dsg_en,
   input  logic       zero_ok,
   input  logic       test_fast,
   output logic       chg_en,
   output logic       ovc_flag,
   output logic       evt_valid,
   output logic [1:0] evt_cause
);
   generate
      if (CELLS != 2) begin : g_bad_cells
         $error("charge_guard: built for exactly two cells");
      end
   endgenerate

   logic ovc_any, rel_all, xc_set, xc_st;

   always_comb begin
      ovc_any = |cell_ovc;
      rel_all = &cell_rel;
      xc_set  = chg_low & dsg_en;
   end

   cg_delay_qual #(.SET_TICKS(OVC_DET_TICKS), .CLR_TICKS(OVC_REL_TICKS)) u_ovc (
      .clk(clk), .rst_n(rst_n), .tick(tick), .fast(test_fast),
      .set_cond(ovc_any), .clr_cond(rel_all), .state(ovc_flag));

   cg_delay_qual #(.SET_TICKS(XC_TICKS), .CLR_TICKS(XC_TICKS)) u_xc (
      .clk(clk), .rst_n(rst_n), .tick(tick), .fast(test_fast),
      .set_cond(xc_set), .clr_cond(~chg_low), .state(xc_st));

   cg_event_out u_out (
      .clk(clk), .rst_n(rst_n), .ovc_st(ovc_flag), .xc_st(xc_st),
      .zero_ok(zero_ok), .chg_en(chg_en), .evt_valid(evt_valid),
      .evt_cause(evt_cause));

   AST_XC_NEEDS_DSG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xc_st) |-> $past(dsg_en));  // R7
   AST_OVC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ovc_flag) && !$past(zero_ok)) |-> !chg_en);  // R2
   AST_REL_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovc_flag) |-> $past(rel_all));  // R4
endmodule

// File: tb/charge_guard_tb_top.sv
module charge_guard_tb_top;
   localparam int DET = 20;
   localparam int REL = 6;
   localparam int XC  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic [1:0] cell_ovc = 2'b00;
   logic [1:0] cell_rel = 2'b00;
   logic chg_low = 1'b0, dsg_en = 1'b1, zero_ok = 1'b0, test_fast = 1'b0;
   logic chg_en, ovc_flag, evt_valid;
   logic [1:0] evt_cause;

   int n_chk = 0;
   int n_bad = 0;
   logic [2:0] exp_q[$];
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   charge_guard #(.OVC_DET_TICKS(DET), .OVC_REL_TICKS(REL), .XC_TICKS(XC)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cell_ovc(cell_ovc),
      .cell_rel(cell_rel), .chg_low(chg_low), .dsg_en(dsg_en),
      .zero_ok(zero_ok), .test_fast(test_fast), .chg_en(chg_en),
      .ovc_flag(ovc_flag), .evt_valid(evt_valid), .evt_cause(evt_cause));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic expect_evt(input logic [1:0] cause, input logic level);
      exp_q.push_back({cause, level});
   endtask

   // Monitor: every event pulse is compared with the queue (R10)
   always @(negedge clk) begin
      if (rst_n && evt_valid) begin
         if (exp_q.size() == 0) begin
            check("R10 unexpected event", 1, 0);
         end else begin
            logic [2:0] e;
            e = exp_q.pop_front();
            check("R10 cause", evt_cause, e[2:1]);
            check("R10 level", chg_en, e[0]);
         end
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 chg_en", chg_en, 1);
      check("R1 ovc_flag", ovc_flag, 0);
      check("R1 evt_valid", evt_valid, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 / R3: overcharge on cell 0, interrupted one tick short
      cell_ovc = 2'b01;
      ticks(DET - 1);
      check("R2 not yet", chg_en, 1);
      cell_ovc = 2'b00;
      ticks(1);
      cell_ovc = 2'b10;
      ticks(DET - 1);
      check("R3 restart", chg_en, 1);
      expect_evt(2'd0, 1'b0);
      ticks(1);
      check("R2 chg_en low", chg_en, 0);
      check("R2 ovc_flag", ovc_flag, 1);

      // R4: release needs both cells
      cell_ovc = 2'b00;
      cell_rel = 2'b01;
      ticks(REL + 4);
      check("R4 one cell holds", chg_en, 0);
      cell_rel = 2'b11;
      ticks(REL - 1);
      check("R4 not yet", chg_en, 0);
      expect_evt(2'd0, 1'b1);
      ticks(1);
      check("R4 released", chg_en, 1);
      check("R4 ovc_flag", ovc_flag, 0);
      cell_rel = 2'b00;

      // R7: suppressed while discharge side off
      dsg_en = 1'b0;
      chg_low = 1'b1;
      ticks(XC + 3);
      check("R7 suppressed", chg_en, 1);
      dsg_en = 1'b1;
      ticks(XC - 1);
      check("R7 counting", chg_en, 1);
      // R6: abandon and restart
      chg_low = 1'b0;
      ticks(1);
      chg_low = 1'b1;
      ticks(XC - 1);
      check("R6 restart", chg_en, 1);
      expect_evt(2'd1, 1'b0);
      ticks(1);
      check("R5 detect", chg_en, 0);
      chg_low = 1'b0;
      ticks(XC - 1);
      check("R5 release wait", chg_en, 0);
      expect_evt(2'd1, 1'b1);
      ticks(1);
      check("R5 released", chg_en, 1);

      // R8: zero-volt permit overrides overcharge
      cell_ovc = 2'b01;
      expect_evt(2'd0, 1'b0);
      ticks(DET);
      check("R8 fault set", chg_en, 0);
      cell_ovc = 2'b00;
      expect_evt(2'd2, 1'b1);
      @(negedge clk) zero_ok = 1'b1;
      repeat (3) @(negedge clk);
      check("R8 forced high", chg_en, 1);
      expect_evt(2'd2, 1'b0);
      @(negedge clk) zero_ok = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 back low", chg_en, 0);
      cell_rel = 2'b11;
      expect_evt(2'd0, 1'b1);
      ticks(REL);
      check("R8 release", chg_en, 1);
      cell_rel = 2'b00;

      // R9: test mode shortens every delay
      test_fast = 1'b1;
      cell_ovc = 2'b10;
      expect_evt(2'd0, 1'b0);
      ticks(1);
      check("R9 ovc detect", chg_en, 0);
      cell_ovc = 2'b00;
      cell_rel = 2'b11;
      expect_evt(2'd0, 1'b1);
      ticks(1);
      check("R9 ovc release", chg_en, 1);
      cell_rel = 2'b00;
      chg_low = 1'b1;
      expect_evt(2'd1, 1'b0);
      ticks(1);
      check("R9 xc detect", chg_en, 0);
      chg_low = 1'b0;
      expect_evt(2'd1, 1'b1);
      ticks(1);
      check("R9 xc release", chg_en, 1);
      test_fast = 1'b0;

      repeat (4) @(negedge clk);
      check("R10 queue drained", exp_q.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule